// File: doc/BRIEF.md
# Register-Mapped Factorial Accelerator

This block is a small memory-mapped peripheral on a 32-bit register bus. Software uses it as a slow coprocessor. It writes an operand, then either polls a busy flag or waits for an interrupt, then reads back the factorial of that operand. Besides the engine, the register window holds a fixed identification word and a scratch register that returns the inverse of whatever was written into it. These two let a driver confirm that the bus path works before it uses the engine.

Interrupts are collected in one status register. Hardware can set its bits, and software can set or clear them through two write-only offsets: one ORs the written value in, the other clears the bits that are set in the written value. The single level-sensitive interrupt output is high whenever any bit of that register is set.

Bus writes take effect on the rising clock edge at which `bus_we_i` is sampled high. Reads are combinational from the current address, access size and register state. Access size is encoded as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes.

Top module: `fact_accel`

## Requirements
- R1: A 4-byte read of offset 0x00 returns 0x010000ED.
- R2: A 4-byte write to offset 0x04 stores the bitwise inverse of the write data, and a 4-byte read of 0x04 returns the stored value.
- R3: A 4-byte write to offset 0x08 while idle latches the operand and sets bit 0 (busy) of the status register at offset 0x20. While busy, a read of 0x08 returns the latched operand.
- R4: A write to offset 0x08 while busy is ignored. The running job and its operand are unchanged.
- R5: The job performs one multiply per clock. Busy stays set for max(n,1) cycles after the write edge. Afterwards 0x08 reads n! truncated to 32 bits, with 0! = 1! = 1.
- R6: Bit 7 of the status register is a software read/write interrupt enable. When a job completes with it set, bit 0 of the interrupt status is set. When it is clear, completion leaves the interrupt status untouched.
- R7: Offset 0x24 reads the interrupt status. A 4-byte write to 0x60 ORs the data into it. A 4-byte write to 0x64 clears every bit that is set in the data.
- R8: `irq_o` is high exactly when the interrupt status is non-zero.
- R9: Below offset 0x80, any access whose size is not 4 bytes is ignored, and such a read returns all ones. Reads of unmapped offsets, including 0x60, 0x64 and anything at or above 0x80, also return all ones.
- R10: If job completion with the enable set and a clear of bit 0 through 0x64 land on the same edge, bit 0 ends up set.
- R11: Synchronous reset clears the scratch register, the enable, the busy flag, the operand and result, and the interrupt status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_size_i | input | 2 | Access size code (2 = 4 bytes) |
| bus_we_i | input | 1 | Write strobe, one write per cycle high |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Combinational read data for the current address |
| irq_o | output | 1 | Level interrupt, high while any interrupt status bit is set |

## Verification
Register writes are visible on the read port one edge after the write cycle. The bench drives each write on a falling edge and reads back after the next falling edge. The engine is the main timing case: for an operand n ≥ 2, busy must still read 1 after n−1 edges beyond the write edge, and 0 after n edges. The bench checks both of those cycles and not just the final result. The collision case in R10 is set up by counting edges so that the clear write is sampled on exactly the edge where the last multiply finishes. Interrupt status and `irq_o` are checked on the same falling edge as the status read.

// File: rtl/fact_accel_pkg.sv
package fact_accel_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } acc_size_e;

   typedef struct packed {
      logic id;
      logic scratch;
      logic oper;
      logic status;
      logic istat;
      logic iraise;
      logic ilower;
   } reg_hit_t;

   localparam int unsigned OFS_ID        = 'h00;
   localparam int unsigned OFS_SCRATCH   = 'h04;
   localparam int unsigned OFS_OPER      = 'h08;
   localparam int unsigned OFS_STATUS    = 'h20;
   localparam int unsigned OFS_ISTAT     = 'h24;
   localparam int unsigned OFS_IRAISE    = 'h60;
   localparam int unsigned OFS_ILOWER    = 'h64;
   localparam int unsigned OFS_WIDE_BASE = 'h80;

   localparam logic [31:0] ID_WORD = 32'h010000ED;

   localparam int unsigned STAT_BUSY_BIT = 0;
   localparam int unsigned STAT_IEN_BIT  = 7;
   localparam int unsigned FACT_IRQ_BIT  = 0;

endpackage

// File: rtl/fact_accel_decode.sv
module fact_accel_decode
   import fact_accel_pkg::*;
#(
   parameter int unsigned ADDR_W = 20
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        size_i,
   output reg_hit_t          hit_o,
   output logic              legal_o
);

   localparam logic [ADDR_W-1:0] A_ID      = ADDR_W'(OFS_ID);
   localparam logic [ADDR_W-1:0] A_SCRATCH = ADDR_W'(OFS_SCRATCH);
   localparam logic [ADDR_W-1:0] A_OPER    = ADDR_W'(OFS_OPER);
   localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);
   localparam logic [ADDR_W-1:0] A_ISTAT   = ADDR_W'(OFS_ISTAT);
   localparam logic [ADDR_W-1:0] A_IRAISE  = ADDR_W'(OFS_IRAISE);
   localparam logic [ADDR_W-1:0] A_ILOWER  = ADDR_W'(OFS_ILOWER);
   localparam logic [ADDR_W-1:0] A_WIDE    = ADDR_W'(OFS_WIDE_BASE);

   if (ADDR_W < 8) begin : g_bad_aw
      $error("fact_accel_decode: ADDR_W must cover offset 0x80");
   end

   logic in_low;

   always_comb begin
      in_low  = (addr_i < A_WIDE);
      // Low window accepts 4-byte accesses only; the wide window would
      // accept 4 or 8 bytes but maps nothing.
      legal_o = in_low ? (size_i == SZ_WORD)
                       : ((size_i == SZ_WORD) || (size_i == SZ_DWORD));
      hit_o.id      = legal_o && (addr_i == A_ID);
      hit_o.scratch = legal_o && (addr_i == A_SCRATCH);
      hit_o.oper    = legal_o && (addr_i == A_OPER);
      hit_o.status  = legal_o && (addr_i == A_STATUS);
      hit_o.istat   = legal_o && (addr_i == A_ISTAT);
      hit_o.iraise  = legal_o && (addr_i == A_IRAISE);
      hit_o.ilower  = legal_o && (addr_i == A_ILOWER);
   end

endmodule

// File: rtl/fact_accel_engine.sv
module fact_accel_engine #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              start_i,
   input  logic [DATA_W-1:0] operand_i,
   output logic              busy_o,
   output logic              finish_o,
   output logic [DATA_W-1:0] value_o
);

   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   if (DATA_W < 2) begin : g_bad_dw
      $error("fact_accel_engine: DATA_W too small");
   end

   logic              busy_q;
   logic [DATA_W-1:0] opnd_q;
   logic [DATA_W-1:0] cnt_q;
   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] factor;
   logic [DATA_W-1:0] product;
   logic              last_step;

   always_comb begin
      last_step = (cnt_q <= ONE);
      factor    = last_step ? ONE : cnt_q;
      product   = acc_q * factor;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         busy_q <= 1'b0;
         opnd_q <= '0;
         cnt_q  <= '0;
         acc_q  <= '0;
      end else if (!busy_q) begin
         if (start_i) begin
            busy_q <= 1'b1;
            opnd_q <= operand_i;
            cnt_q  <= operand_i;
            acc_q  <= ONE;
         end
      end else begin
         acc_q <= product;
         if (last_step) begin
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - ONE;
         end
      end
   end

   assign busy_o   = busy_q;
   assign finish_o = busy_q && last_step;
   assign value_o  = busy_q ? opnd_q : acc_q;

   assert_start_latch_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (start_i && !busy_q) |=> (busy_q && (opnd_q == $past(operand_i))));

   assert_locked_operand_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (start_i && busy_q) |=> $stable(opnd_q));

   assert_busy_holds_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (busy_q && !finish_o) |=> busy_q);

   assert_finish_idle_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      finish_o |=> !busy_q);

endmodule

// File: rtl/fact_accel_irq.sv
module fact_accel_irq #(
   parameter int unsigned IRQ_W   = 32,
   parameter int unsigned SRC_BIT = 0
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             raise_we_i,
   input  logic             lower_we_i,
   input  logic [IRQ_W-1:0] mask_i,
   input  logic             src_evt_i,
   output logic [IRQ_W-1:0] stat_o,
   output logic             irq_o
);

   if (SRC_BIT >= IRQ_W) begin : g_bad_src
      $error("fact_accel_irq: SRC_BIT outside the status word");
   end

   for (genvar b = 0; b < IRQ_W; b++) begin : g_bit
      logic hw_set;
      logic bit_q;

      if (b == SRC_BIT) begin : g_src
         assign hw_set = src_evt_i;
      end else begin : g_nosrc
         assign hw_set = 1'b0;
      end

      // Hardware set outranks a software clear on the same edge.
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            bit_q <= 1'b0;
         end else if (hw_set) begin
            bit_q <= 1'b1;
         end else if (lower_we_i && mask_i[b]) begin
            bit_q <= 1'b0;
         end else if (raise_we_i && mask_i[b]) begin
            bit_q <= 1'b1;
         end
      end

      assign stat_o[b] = bit_q;
   end

   assign irq_o = |stat_o;

   assert_raise_sets_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (raise_we_i && (mask_i != '0)) |=> ((stat_o & $past(mask_i)) == $past(mask_i)));

   assert_lower_clears_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (lower_we_i && !src_evt_i) |=> ((stat_o & $past(mask_i)) == '0));

   assert_src_wins_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      src_evt_i |=> stat_o[SRC_BIT]);

   assert_line_up_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (raise_we_i && (mask_i != '0)) |=> irq_o);

endmodule

// File: rtl/fact_accel.sv
module fact_accel
   import fact_accel_pkg::*;
#(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [1:0]        bus_size_i,
   input  logic              bus_we_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o
);

   if (DATA_W != 32) begin : g_bad_dw
      $error("fact_accel: register word must be 32 bits");
   end

   reg_hit_t          hit;
   logic              legal;
   logic              busy;
   logic              finish;
   logic [DATA_W-1:0] fact_val;
   logic [DATA_W-1:0] istat;
   logic [DATA_W-1:0] scratch_q;
   logic              ien_q;
   logic              low_narrow;

   fact_accel_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr_i  (bus_addr_i),
      .size_i  (bus_size_i),
      .hit_o   (hit),
      .legal_o (legal)
   );

   fact_accel_engine #(.DATA_W(DATA_W)) u_engine (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .start_i   (bus_we_i && hit.oper),
      .operand_i (bus_wdata_i),
      .busy_o    (busy),
      .finish_o  (finish),
      .value_o   (fact_val)
   );

   fact_accel_irq #(.IRQ_W(DATA_W), .SRC_BIT(FACT_IRQ_BIT)) u_irq (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .raise_we_i (bus_we_i && hit.iraise),
      .lower_we_i (bus_we_i && hit.ilower),
      .mask_i     (bus_wdata_i),
      .src_evt_i  (finish && ien_q),
      .stat_o     (istat),
      .irq_o      (irq_o)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         scratch_q <= '0;
         ien_q     <= 1'b0;
      end else if (bus_we_i) begin
         if (hit.scratch) scratch_q <= ~bus_wdata_i;
         if (hit.status)  ien_q     <= bus_wdata_i[STAT_IEN_BIT];
      end
   end

   always_comb begin
      bus_rdata_o = '1;
      if (legal) begin
         unique case (1'b1)
            hit.id:      bus_rdata_o = ID_WORD;
            hit.scratch: bus_rdata_o = scratch_q;
            hit.oper:    bus_rdata_o = fact_val;
            hit.status: begin
               bus_rdata_o                = '0;
               bus_rdata_o[STAT_BUSY_BIT] = busy;
               bus_rdata_o[STAT_IEN_BIT]  = ien_q;
            end
            hit.istat:   bus_rdata_o = istat;
            default:     bus_rdata_o = '1;
         endcase
      end
   end

   assign low_narrow = (bus_addr_i < ADDR_W'(OFS_WIDE_BASE)) && (bus_size_i != SZ_WORD);

   assert_scratch_inv_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (bus_we_i && hit.scratch) |=> (scratch_q == ~$past(bus_wdata_i)));

   assert_narrow_ignored_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      (bus_we_i && low_narrow) |=> ($stable(scratch_q) && $stable(ien_q) && $stable(istat)));

   assert_no_irq_disabled_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (finish && !ien_q && !bus_we_i) |=> $stable(istat));

endmodule

// File: tb/fact_accel_tb.sv
module fact_accel_tb;

   localparam int CLK_P  = 10;
   localparam int ADDR_W = 20;
   localparam logic [1:0] SZ_B = 2'd0;
   localparam logic [1:0] SZ_H = 2'd1;
   localparam logic [1:0] SZ_W = 2'd2;
   localparam logic [1:0] SZ_D = 2'd3;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic [1:0]        size = 2'd2;
   logic              we = 1'b0;
   logic [31:0]       wdata = '0;
   logic [31:0]       rdata;
   logic              irq;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   fact_accel #(.ADDR_W(ADDR_W), .DATA_W(32)) u_dut (
      .clk_i       (clk),
      .rst_i       (rst),
      .bus_addr_i  (addr),
      .bus_size_i  (size),
      .bus_we_i    (we),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .irq_o       (irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [1:0] s);
      addr = a; wdata = d; size = s; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, input logic [1:0] s, output logic [31:0] d);
      addr = a; size = s; we = 1'b0;
      #1;
      d = rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic logic [31:0] fact_ref(input int n);
      logic [31:0] p = 32'd1;
      for (int k = 2; k <= n; k++) p = p * 32'(k);
      return p;
   endfunction

   task automatic do_reset();
      rst = 1'b1;
      idle(2);
      rst = 1'b0;
   endtask

   task automatic t_reset_R11();
      logic [31:0] v;
      wr('h04, 32'h0, SZ_W);
      wr('h20, 32'h80, SZ_W);
      wr('h60, 32'h5, SZ_W);
      wr('h08, 32'd6, SZ_W);
      do_reset();
      rd('h04, SZ_W, v); chk("R11 scratch", v, 32'h0);
      rd('h20, SZ_W, v); chk("R11 status", v, 32'h0);
      rd('h24, SZ_W, v); chk("R11 istat", v, 32'h0);
      rd('h08, SZ_W, v); chk("R11 result", v, 32'h0);
      chk("R11 irq", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_id_R1();
      logic [31:0] v;
      rd('h00, SZ_W, v); chk("R1 id", v, 32'h010000ED);
   endtask

   task automatic t_scratch_R2();
      logic [31:0] v;
      wr('h04, 32'h1234_5678, SZ_W);
      rd('h04, SZ_W, v); chk("R2 inverse", v, 32'hEDCB_A987);
      wr('h04, 32'hFFFF_FFFF, SZ_W);
      rd('h04, SZ_W, v); chk("R2 zero", v, 32'h0);
   endtask

   task automatic run_fact_R5(input int n);
      logic [31:0] v;
      int busy_cycles = (n < 1) ? 1 : n;
      wr('h08, 32'(n), SZ_W);
      rd('h20, SZ_W, v); chk("R3 busy set", v & 32'h1, 32'h1);
      rd('h08, SZ_W, v); chk("R3 operand readback", v, 32'(n));
      if (busy_cycles > 1) begin
         idle(busy_cycles - 1);
         rd('h20, SZ_W, v); chk("R5 busy before last", v & 32'h1, 32'h1);
         idle(1);
      end else begin
         idle(1);
      end
      rd('h20, SZ_W, v); chk("R5 busy cleared", v & 32'h1, 32'h0);
      rd('h08, SZ_W, v); chk("R5 result", v, fact_ref(n));
   endtask

   task automatic t_lockout_R4();
      logic [31:0] v;
      wr('h08, 32'd4, SZ_W);
      wr('h08, 32'd9, SZ_W);
      rd('h08, SZ_W, v); chk("R4 operand kept", v, 32'd4);
      idle(3);
      rd('h20, SZ_W, v); chk("R4 busy timing", v & 32'h1, 32'h0);
      rd('h08, SZ_W, v); chk("R4 result", v, 32'd24);
   endtask

   task automatic t_irq_en_R6();
      logic [31:0] v;
      wr('h64, 32'hFFFF_FFFF, SZ_W);
      wr('h20, 32'h0, SZ_W);
      wr('h08, 32'd3, SZ_W);
      idle(4);
      rd('h24, SZ_W, v); chk("R6 disabled no irq", v, 32'h0);
      chk("R8 line low", {31'b0, irq}, 32'h0);
      wr('h20, 32'h80, SZ_W);
      rd('h20, SZ_W, v); chk("R6 enable readback", v, 32'h80);
      wr('h08, 32'd3, SZ_W);
      idle(3);
      rd('h24, SZ_W, v); chk("R6 completion irq", v, 32'h1);
      chk("R8 line high", {31'b0, irq}, 32'h1);
      wr('h64, 32'h1, SZ_W);
      chk("R8 line low again", {31'b0, irq}, 32'h0);
      wr('h20, 32'h0, SZ_W);
   endtask

   task automatic t_raise_lower_R7();
      logic [31:0] v;
      wr('h60, 32'hA000_0100, SZ_W);
      wr('h60, 32'h0000_0003, SZ_W);
      rd('h24, SZ_W, v); chk("R7 raise or", v, 32'hA000_0103);
      chk("R8 line", {31'b0, irq}, 32'h1);
      wr('h64, 32'h2000_0101, SZ_W);
      rd('h24, SZ_W, v); chk("R7 lower", v, 32'h8000_0002);
      wr('h64, 32'h8000_0002, SZ_W);
      rd('h24, SZ_W, v); chk("R7 empty", v, 32'h0);
      chk("R8 line clear", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_narrow_R9();
      logic [31:0] v;
      wr('h04, 32'h0000_00FF, SZ_W);
      wr('h04, 32'h0, SZ_B);
      wr('h04, 32'h0, SZ_D);
      rd('h04, SZ_W, v); chk("R9 narrow write ignored", v, 32'hFFFF_FF00);
      rd('h04, SZ_H, v); chk("R9 narrow read", v, 32'hFFFF_FFFF);
      rd('h00, SZ_B, v); chk("R9 narrow id", v, 32'hFFFF_FFFF);
      wr('h08, 32'd5, SZ_H);
      rd('h20, SZ_W, v); chk("R9 narrow start ignored", v, 32'h0);
      wr('h60, 32'h4, SZ_B);
      rd('h24, SZ_W, v); chk("R9 narrow raise ignored", v, 32'h0);
      rd('h40, SZ_W, v); chk("R9 unmapped", v, 32'hFFFF_FFFF);
      rd('h60, SZ_W, v); chk("R9 raise reads ones", v, 32'hFFFF_FFFF);
      rd('h80, SZ_W, v); chk("R9 wide region", v, 32'hFFFF_FFFF);
   endtask

   task automatic t_collide_R10();
      logic [31:0] v;
      wr('h20, 32'h80, SZ_W);
      wr('h08, 32'd2, SZ_W);
      idle(1);
      wr('h64, 32'h1, SZ_W);
      rd('h20, SZ_W, v); chk("R10 job done", v & 32'h1, 32'h0);
      rd('h24, SZ_W, v); chk("R10 set wins", v, 32'h1);
      wr('h64, 32'h1, SZ_W);
      wr('h20, 32'h0, SZ_W);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      @(negedge clk);
      do_reset();
      rd('h24, SZ_W, v); chk("R11 reset istat", v, 32'h0);
      rd('h20, SZ_W, v); chk("R11 reset status", v, 32'h0);
      t_id_R1();
      t_scratch_R2();
      run_fact_R5(5);
      run_fact_R5(0);
      run_fact_R5(1);
      run_fact_R5(2);
      run_fact_R5(13);
      t_lockout_R4();
      t_irq_en_R6();
      t_raise_lower_R7();
      t_narrow_R9();
      t_collide_R10();
      t_reset_R11();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule